// File: doc/BRIEF.md
# Iterative Multi-Configuration CORDIC Engine

This block computes rotations and vector angles with the CORDIC shift-add recurrence, one micro-rotation per clock. A single datapath serves three coordinate systems: circular (sine, cosine, magnitude, arctangent), linear (multiply, divide) and hyperbolic (hyperbolic sine and cosine, inverse hyperbolic tangent). Each system runs in one of two modes. In rotation mode the X/Y vector is turned until the Z register is driven to zero. In vectoring mode the vector is turned onto the X axis and Z collects the total angle.

The caller presents signed fixed-point X, Y and Z operands together with a configuration and a mode, and pulses `start`. After a fixed number of clocks, `done` pulses for one cycle and the three result registers hold their values until the next accepted start. Inputs must already lie inside the convergence zone. The caller folds any gain compensation into the initial X, and the block applies no scaling to its results. The angle constants for each step are computed at elaboration time and held in an internal table.

The numeric format is as follows. Inputs are `DATA_W` bits wide with `DATA_W-2` fraction bits. Internal registers and outputs are `DATA_W+2` bits wide and carry the same fraction bits, which leaves headroom for gain growth.

Top module: `cordic_iter_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, the engine becomes idle, `done` goes low and all three outputs go to zero.
- R2: `cfg_sel` 2'b00 selects circular. Each step updates x to x − d·(y>>>i), y to y + d·(x>>>i) and z to z − d·atan(2^-i), for i = 0, 1, 2, and so on. In rotation mode (`mode_sel` = 0), d is −1 when z is negative and +1 otherwise.
- R3: In vectoring mode (`mode_sel` = 1), d is +1 when y is negative and −1 otherwise. This drives y toward zero while z accumulates the angle.
- R4: `cfg_sel` 2'b01 selects linear. Here x never changes, y is updated to y + d·(x>>>i) and z to z − d·2^-i, starting at i = 0.
- R5: `cfg_sel` 2'b10 selects hyperbolic. Here x is updated to x + d·(y>>>i) and z to z − d·atanh(2^-i). The shift index starts at 1, and indices 4, 13, 40 (each 3k+1 of the previous) are each used for two consecutive steps.
- R6: Each angle constant equals the exact value rounded to the nearest multiple of 2^-(DATA_W-2).
- R7: An accepted start is followed by exactly `NUM_ITERS` steps, one per clock. `done` is high for exactly one cycle, in the cycle after the last step's clock edge, and the final results are on the outputs in that same cycle.
- R8: A start that arrives while a computation is in progress has no effect on that computation or on its timing.
- R9: While idle and with no start, the outputs keep their values.
- R10: `cfg_sel` 2'b11 behaves exactly like circular.
- R11: Inputs are sign-extended into the wider registers and all shifts are arithmetic, so results up to ±8 (beyond the input range) come out without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a computation; accepted only when idle |
| cfg_sel | input | 2 | 00 circular, 01 linear, 10 hyperbolic, 11 circular |
| mode_sel | input | 1 | 0 rotation, 1 vectoring |
| x_in | input | DATA_W | Initial X, signed |
| y_in | input | DATA_W | Initial Y, signed |
| z_in | input | DATA_W | Initial Z (radians), signed |
| x_out | output | DATA_W+2 | X register, signed |
| y_out | output | DATA_W+2 | Y register, signed |
| z_out | output | DATA_W+2 | Z register, signed |
| done | output | 1 | One-cycle pulse when the results are final |

## Verification
The hardest case to reach is the repeated hyperbolic step. The step at shift 4 must run twice, and only in hyperbolic configuration. An error there changes the results by a few LSBs, which is easy to miss. The bench runs hyperbolic rotation and vectoring against a per-clock model. The model builds its own step schedule, uses real-valued atanh constants, and compares all three registers on every clock, so a missing or misplaced repeat shows up in the cycle where it happens. A second start pulse is injected part-way through a run to show that the computation in progress and its timing are unchanged.

// File: rtl/cordic_pkg.sv
// Shared types and elaboration-time angle constant generators.
// Assumes the Q60 intermediate scale gives far more precision than any
// realistic output fraction width.
package cordic_pkg;

    typedef enum logic [1:0] {
        CFG_CIRC = 2'b00,
        CFG_LIN  = 2'b01,
        CFG_HYP  = 2'b10,
        CFG_ALT  = 2'b11
    } cfg_e;

    localparam longint PI_OVER4_Q60 = 64'sd905502432259640373;

    // Series value of atan or atanh of 2^-i, scaled by 2^60 (elaboration only).
    function automatic longint angle_q60(input int i, input bit hyp);
        longint acc;
        longint t;
        int     sh;
        acc = 0;
        if (i == 0) return hyp ? 64'sd0 : PI_OVER4_Q60;
        for (int k = 0; k < 40; k++) begin
            sh = i * (2 * k + 1);
            if (sh < 61) begin
                t = (64'sd1 <<< 60) >>> sh;
                t = t / longint'(2 * k + 1);
                if (hyp || (k % 2 == 0)) acc = acc + t;
                else                     acc = acc - t;
            end
        end
        return acc;
    endfunction

    // Round a Q60 value to the nearest step of 2^-frac.
    function automatic longint round_q(input longint v, input int frac);
        return (v + (64'sd1 <<< (59 - frac))) >>> (60 - frac);
    endfunction

endpackage

// File: rtl/cordic_angle_rom.sv
// Angle constant table for all three coordinate systems.
// Assumes idx never exceeds DEPTH-1; unknown configurations read circular.
module cordic_angle_rom
    import cordic_pkg::*;
#(
    parameter int W     = 18,
    parameter int FRAC  = 14,
    parameter int DEPTH = 17,
    parameter int IDXW  = 5
) (
    input  cfg_e                   cfg,
    input  logic [IDXW-1:0]        idx,
    output logic signed [W-1:0]    angle
);

    logic signed [W-1:0] circ_tab [DEPTH];
    logic signed [W-1:0] lin_tab  [DEPTH];
    logic signed [W-1:0] hyp_tab  [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam longint C_Q = round_q(angle_q60(g, 1'b0), FRAC);
        localparam longint H_Q = round_q(angle_q60(g, 1'b1), FRAC);
        localparam longint L_Q = round_q((64'sd1 <<< 60) >>> g, FRAC);
        assign circ_tab[g] = C_Q[W-1:0];
        assign hyp_tab[g]  = H_Q[W-1:0];
        assign lin_tab[g]  = L_Q[W-1:0];
    end

    // Select the table for the latched configuration.
    always_comb begin
        unique case (cfg)
            CFG_LIN: angle = lin_tab[idx];
            CFG_HYP: angle = hyp_tab[idx];
            default: angle = circ_tab[idx];
        endcase
    end

endmodule

// File: rtl/cordic_seq.sv
// Step counter and shift-index schedule, including hyperbolic repeats.
// Assumes load and run are never high together.
module cordic_seq #(
    parameter int NUM_ITERS = 16,
    parameter int SHW       = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           hyp_load,
    input  logic           run,
    input  logic           hyp_run,
    output logic [SHW-1:0] shift,
    output logic           last
);

    localparam int RPW = SHW + 4;

    logic [SHW-1:0] step_q;
    logic [SHW-1:0] shift_q;
    logic [RPW-1:0] rep_q;
    logic           twice_q;

    assign shift = shift_q;
    assign last  = (step_q == SHW'(NUM_ITERS - 1));

    // Advance step count and shift index; hold a repeat index for one extra step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q  <= '0;
            shift_q <= '0;
            rep_q   <= RPW'(4);
            twice_q <= 1'b0;
        end else if (load) begin
            step_q  <= '0;
            shift_q <= hyp_load ? SHW'(1) : '0;
            rep_q   <= RPW'(4);
            twice_q <= 1'b0;
        end else if (run) begin
            step_q <= step_q + 1'b1;
            if (hyp_run && (RPW'(shift_q) == rep_q) && !twice_q) begin
                twice_q <= 1'b1;
            end else begin
                shift_q <= shift_q + 1'b1;
                if (twice_q) begin
                    twice_q <= 1'b0;
                    rep_q   <= (rep_q << 1) + rep_q + RPW'(1);
                end
            end
        end
    end

    assert_hyp_nonzero_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hyp_run) |-> (shift_q != '0));

    assert_step_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !last) |=> (step_q == $past(step_q) + 1'b1));

endmodule

// File: rtl/cordic_microrot.sv
// One combinational CORDIC micro-rotation for any configuration and mode.
// Assumes shift is below W; uses only shifts and add/subtract.
module cordic_microrot
    import cordic_pkg::*;
#(
    parameter int W   = 18,
    parameter int SHW = 5
) (
    input  cfg_e                 cfg,
    input  logic                 vectoring,
    input  logic [SHW-1:0]       shift,
    input  logic signed [W-1:0]  x,
    input  logic signed [W-1:0]  y,
    input  logic signed [W-1:0]  z,
    input  logic signed [W-1:0]  e,
    output logic signed [W-1:0]  x_n,
    output logic signed [W-1:0]  y_n,
    output logic signed [W-1:0]  z_n
);

    logic signed [W-1:0] xs;
    logic signed [W-1:0] ys;
    logic                neg_dir;

    // Direction decision and shift-add update.
    always_comb begin
        xs      = x >>> shift;
        ys      = y >>> shift;
        neg_dir = vectoring ? !y[W-1] : z[W-1];
        y_n     = neg_dir ? (y - xs) : (y + xs);
        z_n     = neg_dir ? (z + e)  : (z - e);
        unique case (cfg)
            CFG_LIN: x_n = x;
            CFG_HYP: x_n = neg_dir ? (x - ys) : (x + ys);
            default: x_n = neg_dir ? (x + ys) : (x - ys);
        endcase
    end

endmodule

// File: rtl/cordic_iter_engine.sv
// Iterative CORDIC engine: loads operands on start, runs NUM_ITERS
// micro-rotations one per clock, then pulses done with results held.
// Assumes inputs lie in the convergence zone and gain is pre-applied to X.
module cordic_iter_engine
    import cordic_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int GUARD     = 2,
    parameter int NUM_ITERS = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [1:0]                    cfg_sel,
    input  logic                          mode_sel,
    input  logic signed [DATA_W-1:0]      x_in,
    input  logic signed [DATA_W-1:0]      y_in,
    input  logic signed [DATA_W-1:0]      z_in,
    output logic signed [DATA_W+GUARD-1:0] x_out,
    output logic signed [DATA_W+GUARD-1:0] y_out,
    output logic signed [DATA_W+GUARD-1:0] z_out,
    output logic                          done
);

    localparam int W     = DATA_W + GUARD;
    localparam int FRAC  = DATA_W - 2;
    localparam int DEPTH = NUM_ITERS + 1;
    localparam int SHW   = $clog2(DEPTH);

    logic signed [W-1:0] x_q, y_q, z_q;
    logic signed [W-1:0] x_n, y_n, z_n;
    logic signed [W-1:0] angle;
    logic                busy_q;
    logic                done_q;
    logic                mode_q;
    cfg_e                cfg_q;
    logic [SHW-1:0]      shift;
    logic                last;
    logic                accept;

    assign accept = start && !busy_q;
    assign x_out  = x_q;
    assign y_out  = y_q;
    assign z_out  = z_q;
    assign done   = done_q;

    cordic_seq #(.NUM_ITERS(NUM_ITERS), .SHW(SHW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .hyp_load (cfg_e'(cfg_sel) == CFG_HYP),
        .run      (busy_q),
        .hyp_run  (cfg_q == CFG_HYP),
        .shift    (shift),
        .last     (last)
    );

    cordic_angle_rom #(.W(W), .FRAC(FRAC), .DEPTH(DEPTH), .IDXW(SHW)) u_rom (
        .cfg   (cfg_q),
        .idx   (shift),
        .angle (angle)
    );

    cordic_microrot #(.W(W), .SHW(SHW)) u_rot (
        .cfg       (cfg_q),
        .vectoring (mode_q),
        .shift     (shift),
        .x         (x_q),
        .y         (y_q),
        .z         (z_q),
        .e         (angle),
        .x_n       (x_n),
        .y_n       (y_n),
        .z_n       (z_n)
    );

    // Operand load, per-cycle iteration and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q    <= '0;
            y_q    <= '0;
            z_q    <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            mode_q <= 1'b0;
            cfg_q  <= CFG_CIRC;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                x_q    <= {{GUARD{x_in[DATA_W-1]}}, x_in};
                y_q    <= {{GUARD{y_in[DATA_W-1]}}, y_in};
                z_q    <= {{GUARD{z_in[DATA_W-1]}}, z_in};
                cfg_q  <= cfg_e'(cfg_sel);
                mode_q <= mode_sel;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                x_q <= x_n;
                y_q <= y_n;
                z_q <= z_n;
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assert_done_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> done);

    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !start) |=> ($stable(x_out) && $stable(y_out) && $stable(z_out)));

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start && !last) |=> (busy_q && $stable(cfg_q) && $stable(mode_q)));

    assert_linear_x_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cfg_q == CFG_LIN) |=> $stable(x_out));

endmodule

// File: tb/cordic_iter_engine_tb_top.sv
module cordic_iter_engine_tb_top;

    localparam int  DATA_W  = 16;
    localparam int  W       = DATA_W + 2;
    localparam int  FRAC    = DATA_W - 2;
    localparam int  N       = 16;
    localparam time CLK_PER = 10ns;
    localparam real ONE     = 16384.0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] cfg_sel = 2'b00;
    logic mode_sel = 1'b0;
    logic signed [DATA_W-1:0] x_in = '0, y_in = '0, z_in = '0;
    logic signed [W-1:0] x_o, y_o, z_o;
    logic done_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PER/2) clk = ~clk;

    cordic_iter_engine #(.DATA_W(DATA_W), .GUARD(2), .NUM_ITERS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_sel(cfg_sel),
        .mode_sel(mode_sel), .x_in(x_in), .y_in(y_in), .z_in(z_in),
        .x_out(x_o), .y_out(y_o), .z_out(z_o), .done(done_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic longint wrap(input longint v);
        longint m;
        m = 64'sd1 <<< W;
        v = v & (m - 1);
        if (v >= (m >>> 1)) v = v - m;
        return v;
    endfunction

    function automatic longint ref_angle(input int c, input int s);
        real r;
        if (c == 1)      r = 2.0 ** (-s);
        else if (c == 2) r = (s == 0) ? 0.0 : $atanh(2.0 ** (-s));
        else             r = $atan(2.0 ** (-s));
        return longint'(r * (2.0 ** FRAC));
    endfunction

    // Reference model state
    bit     m_busy, m_done, m_vec;
    int     m_cfg, m_step, m_sh, m_rep;
    bit     m_twice;
    longint m_x, m_y, m_z;

    // Behavioural model, advanced on each rising edge.
    always @(posedge clk) begin
        longint sx, sy, nx, ny, nz;
        int d, mm;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_x = 0; m_y = 0; m_z = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                sx = m_x >>> m_sh;
                sy = m_y >>> m_sh;
                if (m_vec) d = (m_y < 0) ? 1 : -1;
                else       d = (m_z < 0) ? -1 : 1;
                mm = (m_cfg == 1) ? 0 : (m_cfg == 2) ? -1 : 1;
                nx = m_x - mm * d * sy;
                ny = m_y + d * sx;
                nz = m_z - d * ref_angle(m_cfg, m_sh);
                m_x = wrap(nx); m_y = wrap(ny); m_z = wrap(nz);
                m_step++;
                if (m_cfg == 2 && m_sh == m_rep && !m_twice) m_twice = 1;
                else begin
                    if (m_twice) begin m_twice = 0; m_rep = 3 * m_rep + 1; end
                    m_sh++;
                end
                if (m_step == N) begin m_busy = 0; m_done = 1; end
            end else if (start) begin
                m_x = longint'(x_in); m_y = longint'(y_in); m_z = longint'(z_in);
                m_cfg = int'(cfg_sel); m_vec = mode_sel;
                m_busy = 1; m_step = 0; m_sh = (m_cfg == 2) ? 1 : 0;
                m_rep = 4; m_twice = 0;
            end
        end
    end

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        string tag;
        if (rst_n) begin
            if (!m_busy && !m_done) tag = "R9";
            else if (m_cfg == 3)    tag = "R10";
            else if (m_cfg == 1)    tag = "R4";
            else if (m_cfg == 2)    tag = "R5";
            else                    tag = m_vec ? "R3" : "R2";
            check(longint'(x_o) == m_x, {tag, " x R6"}, longint'(x_o), m_x);
            check(longint'(y_o) == m_y, {tag, " y R6"}, longint'(y_o), m_y);
            check(longint'(z_o) == m_z, {tag, " z R6"}, longint'(z_o), m_z);
            check(done_o == m_done, "R7 done", longint'(done_o), longint'(m_done));
        end
    end

    task automatic run_op(input logic [1:0] c, input logic m, input int x, input int y,
                          input int z, input bit intrude);
        int cnt;
        @(negedge clk);
        cfg_sel = c; mode_sel = m;
        x_in = DATA_W'(x); y_in = DATA_W'(y); z_in = DATA_W'(z);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        while (!done_o && cnt < 4 * N) begin
            if (intrude && cnt == 3) begin
                start = 1'b1; cfg_sel = 2'b01; x_in = 16'sd100; y_in = 16'sd200; z_in = -16'sd300;
            end else start = 1'b0;
            @(negedge clk);
            cnt++;
        end
        start = 1'b0;
        check(cnt == N + 1, intrude ? "R8 latency" : "R7 latency", cnt, N + 1);
    endtask

    function automatic bit near(input longint act, input real exp_val);
        real diff;
        diff = real'(act) - exp_val * ONE;
        return (diff < 40.0) && (diff > -40.0);
    endfunction

    initial begin
        longint hx, hy, hz;
        repeat (3) @(negedge clk);
        check(x_o == 0 && y_o == 0 && z_o == 0, "R1 outputs zero", longint'(x_o), 0);
        check(done_o == 1'b0, "R1 done low", longint'(done_o), 0);
        rst_n = 1'b1;

        // R2 circular rotation, positive and negative angles
        run_op(2'b00, 1'b0, 9949, 0, 8192, 0);
        check(near(x_o, $cos(0.5)), "R2 cos", x_o, longint'($cos(0.5) * ONE));
        check(near(y_o, $sin(0.5)), "R2 sin", y_o, longint'($sin(0.5) * ONE));
        run_op(2'b00, 1'b0, 9949, 0, -16384, 0);
        check(near(y_o, $sin(-1.0)), "R2 sin neg", y_o, longint'($sin(-1.0) * ONE));

        // R3 circular vectoring, both signs of y
        run_op(2'b00, 1'b1, 8192, 11469, 0, 0);
        check(near(z_o, $atan(1.4)), "R3 atan", z_o, longint'($atan(1.4) * ONE));
        check(near(y_o, 0.0), "R3 y to zero", y_o, 0);
        run_op(2'b00, 1'b1, 8192, -11469, 0, 0);
        check(near(z_o, -$atan(1.4)), "R3 atan neg", z_o, longint'(-$atan(1.4) * ONE));

        // R4 linear multiply and divide
        run_op(2'b01, 1'b0, 12288, 0, 8192, 0);
        check(near(y_o, 0.375), "R4 multiply", y_o, 6144);
        check(x_o == 12288, "R4 x unchanged", x_o, 12288);
        run_op(2'b01, 1'b1, 16384, 4915, 0, 0);
        check(near(z_o, 0.3), "R4 divide", z_o, 4915);

        // R5 hyperbolic rotation and vectoring
        run_op(2'b10, 1'b0, 19784, 0, 8192, 0);
        check(near(x_o, $cosh(0.5)), "R5 cosh", x_o, longint'($cosh(0.5) * ONE));
        check(near(y_o, $sinh(0.5)), "R5 sinh", y_o, longint'($sinh(0.5) * ONE));
        run_op(2'b10, 1'b1, 16384, 8192, 0, 0);
        check(near(z_o, $atanh(0.5)), "R5 atanh", z_o, longint'($atanh(0.5) * ONE));

        // R10 reserved code equals circular
        run_op(2'b00, 1'b0, 9949, 3000, -5000, 0);
        hx = x_o; hy = y_o; hz = z_o;
        run_op(2'b11, 1'b0, 9949, 3000, -5000, 0);
        check(x_o == hx && y_o == hy && z_o == hz, "R10 same as circular", x_o, hx);

        // R8 start during a run is ignored
        run_op(2'b00, 1'b0, 9949, 0, 8192, 1);
        check(near(x_o, $cos(0.5)), "R8 result intact", x_o, longint'($cos(0.5) * ONE));

        // R9 outputs hold while idle
        hx = x_o;
        repeat (6) @(negedge clk);
        check(x_o == hx, "R9 hold", x_o, hx);

        // R11 growth past the input range
        run_op(2'b00, 1'b1, 31130, 31130, 0, 0);
        check(x_o > 32767, "R11 guard headroom", x_o, 32768);
        check(near(x_o, 1.9 * $sqrt(2.0) / 0.607253), "R11 magnitude", x_o,
              longint'(1.9 * $sqrt(2.0) / 0.607253 * ONE));

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule